// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a small memory-mapped status register that remembers which kinds of reset the chip has gone through. Four reset sources reach it as single-cycle event pulses: power-on, external pin, brown-out and watchdog. Each pulse sets its own flag. The flags survive the non-power-on resets, so that after any reset software can read the register and find out what caused it.

Software reads the flags over a simple single-cycle bus. It clears a flag by writing 0 to that bit, and writing 1 to a bit leaves it as it is. The register answers at two addresses: a data-space address and an I/O-space alias that lies 0x20 below it. A power-on event clears the three other flags while it sets its own. The power-on flag can only be cleared by software.

The bus signal `rst_n` only brings the register to its all-zero starting value. It is not one of the recorded reset causes.

Top module: `rst_cause_reg`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every flag is 0 and a read at a decoded address returns 0x00.
- R2: Each event input sets its own flag at the clock edge where it is sampled: bit 3 is set by `evt_wdog`, bit 2 by `evt_brown`, bit 1 by `evt_pin` and bit 0 by `evt_pwr`. A read shows the new value in the cycle after the event.
- R3: An `evt_pwr` pulse sets bit 0 and clears bits 3, 2 and 1, unless a flag's own event arrives in the same cycle.
- R4: `evt_wdog`, `evt_brown` and `evt_pin` change only their own bit. Other flags, including bit 0, keep their value, so several flags can be set at the same time.
- R5: A write to a decoded address clears each flag bit 3..0 whose write-data bit is 0. Flags whose write-data bit is 1 are left unchanged.
- R6: The register decodes data address 0x54 (`DATA_ADDR`) and I/O alias 0x34 (`DATA_ADDR - IO_OFFSET`). At any other address `bus_hit` is 0, `bus_rdata` is 0x00, and writes have no effect.
- R7: Bits 7..4 always read as 0, and writes to those bits are ignored.
- R8: When a flag's event and a write of 0 to that flag fall in the same cycle, the event wins and the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset, released synchronously |
| evt_pwr | input | 1 | Power-on reset event pulse |
| evt_pin | input | 1 | External pin reset event pulse |
| evt_brown | input | 1 | Brown-out reset event pulse |
| evt_wdog | input | 1 | Watchdog reset event pulse |
| bus_addr | input | 8 | Bus byte address |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 8 | Write data; a 0 in bits 3..0 clears that flag |
| bus_rdata | output | 8 | Read data, 0x00 when the address misses |
| bus_hit | output | 1 | High when the address matches either alias |

## Verification
The hardest cases to reach from the ports are collisions in a single cycle. Examples are a write of 0 landing in the same edge as the event for that flag, and a power-on pulse arriving together with other events or with a clearing write. Directed steps place these pairs exactly on one edge. A seeded random phase then fires events and writes at both aliases and at nearby missing addresses, with probabilities high enough that overlaps happen often. After every step the bench reads back through alternating aliases and compares the result against a bench model of the flags.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int NUM_FLAGS = 4;

  typedef enum int unsigned {
    FLG_PWR   = 0,
    FLG_PIN   = 1,
    FLG_BROWN = 2,
    FLG_WDOG  = 3
  } flag_idx_e;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rcr_addr_decode.sv
module rcr_addr_decode #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  DATA_ADDR = 8'h54,
  parameter logic [7:0]  IO_OFFSET = 8'h20
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] DATA_MATCH = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] IO_MATCH   = ADDR_W'(DATA_ADDR - IO_OFFSET);

  always_comb begin
    hit_o = (addr_i == DATA_MATCH) || (addr_i == IO_MATCH);
  end
endmodule

// File: rtl/rcr_flag_bit.sv
module rcr_flag_bit #(
  parameter bit CLR_ON_POR = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic por_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic q_o
);
  logic d;
  logic en;

  // priority: own event, then power-on clear, then write-zero clear
  always_comb begin
    en = set_i | (CLR_ON_POR & por_i) | wr_en_i;
    if (set_i)
      d = 1'b1;
    else if (CLR_ON_POR && por_i)
      d = 1'b0;
    else if (wr_en_i && !wr_bit_i)
      d = 1'b0;
    else
      d = q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_o <= 1'b0;
    else if (en)
      q_o <= d;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] DATA_ADDR = 8'h54,
  parameter logic [7:0] IO_OFFSET = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_pwr,
  input  logic              evt_pin,
  input  logic              evt_brown,
  input  logic              evt_wdog,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_hit
);
  import rcr_pkg::*;

  localparam int PAD_W = DATA_W - NUM_FLAGS;

  flag_vec_t events;
  flag_vec_t flags_q;
  logic      wr_en;
  logic      unused_wdata_hi;

  always_comb begin
    events           = '0;
    events[FLG_PWR]   = evt_pwr;
    events[FLG_PIN]   = evt_pin;
    events[FLG_BROWN] = evt_brown;
    events[FLG_WDOG]  = evt_wdog;
  end

  rcr_addr_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_ADDR(DATA_ADDR),
    .IO_OFFSET(IO_OFFSET)
  ) u_dec (
    .addr_i(bus_addr),
    .hit_o (bus_hit)
  );

  assign wr_en           = bus_hit & bus_we;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_FLAGS];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    rcr_flag_bit #(
      .CLR_ON_POR(i != FLG_PWR)
    ) u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (events[i]),
      .por_i   (evt_pwr),
      .wr_en_i (wr_en),
      .wr_bit_i(bus_wdata[i]),
      .q_o     (flags_q[i])
    );
  end

  always_comb begin
    if (bus_hit)
      bus_rdata = {{PAD_W{1'b0}}, flags_q};
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] DATA_ADDR = 8'h54,
  parameter logic [7:0] IO_OFFSET = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_pwr,
  input logic              evt_pin,
  input logic              evt_brown,
  input logic              evt_wdog,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [3:0]        wr_low,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_hit,
  input logic [3:0]        flags_q
);
  logic       wr;
  logic       any_evt;
  logic [3:0] evs;
  assign wr      = bus_hit & bus_we;
  assign evs     = {evt_wdog, evt_brown, evt_pin, evt_pwr};
  assign any_evt = |evs;

  always_comb begin
    if (rst_n) begin
      assert_pad_zero_R7: assert (bus_rdata[DATA_W-1:4] == '0);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (flags_q == 4'b0000) || !rst_n);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> ((flags_q & $past(evs)) == $past(evs)));

  assert_por_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pwr && !evt_pin && !evt_brown && !evt_wdog) |=> flags_q == 4'b0001);

  assert_other_evt_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_evt && !evt_pwr && !wr) |=> flags_q == ($past(flags_q) | $past(evs)));

  assert_write_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !any_evt) |=> flags_q == ($past(flags_q) & $past(wr_low)));

  assert_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(DATA_ADDR) && bus_addr != ADDR_W'(DATA_ADDR - IO_OFFSET))
      |-> (!bus_hit && bus_rdata == '0));

  assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |-> bus_rdata[3:0] == flags_q);

  assert_evt_beats_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pin && wr && !wr_low[1]) |=> flags_q[1]);
endmodule

bind rst_cause_reg rcr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_ADDR(DATA_ADDR), .IO_OFFSET(IO_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pwr(evt_pwr), .evt_pin(evt_pin),
  .evt_brown(evt_brown), .evt_wdog(evt_wdog), .bus_addr(bus_addr),
  .bus_we(bus_we), .wr_low(bus_wdata[3:0]), .bus_rdata(bus_rdata),
  .bus_hit(bus_hit), .flags_q(flags_q)
);

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'h54;
  localparam logic [7:0] A_IO   = 8'h34;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_pwr, evt_pin, evt_brown, evt_wdog;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_we, bus_hit;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model;
  bit         alias_sel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pwr(evt_pwr), .evt_pin(evt_pin),
    .evt_brown(evt_brown), .evt_wdog(evt_wdog), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_hit(bus_hit)
  );

  // ev order: {wdog, brown, pin, pwr}
  function automatic logic [3:0] next_flags(logic [3:0] f, logic [3:0] ev,
                                            logic hit, logic we, logic [7:0] wd);
    logic [3:0] r;
    r = f;
    if (hit && we) r = r & wd[3:0];
    if (ev[0]) r = r & 4'b0001;
    r = r | ev;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic [3:0] ev, logic [7:0] addr,
                      logic we, logic [7:0] wd);
    logic hit;
    @(negedge clk);
    {evt_wdog, evt_brown, evt_pin, evt_pwr} = ev;
    bus_addr = addr; bus_we = we; bus_wdata = wd;
    hit = (addr == A_DATA) || (addr == A_IO);
    #1;
    check({req, " hit"}, {31'd0, bus_hit}, {31'd0, hit});
    if (!hit) check({req, " miss rdata"}, {24'd0, bus_rdata}, 32'd0);
    @(posedge clk);
    model = next_flags(model, ev, hit, we, wd);
    #1;
    {evt_wdog, evt_brown, evt_pin, evt_pwr} = 4'b0;
    bus_we = 1'b0; bus_wdata = 8'h00;
    alias_sel = ~alias_sel;
    bus_addr = alias_sel ? A_IO : A_DATA;
    #1;
    check(req, {24'd0, bus_rdata}, {28'd0, model});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [7:0] a;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; model = 4'h0;
    {evt_wdog, evt_brown, evt_pin, evt_pwr} = 4'b0;
    bus_addr = A_DATA; bus_we = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", {24'd0, bus_rdata}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1 after release", {24'd0, bus_rdata}, 32'd0);

    step("R2 pwr sets bit0", 4'b0001, 8'h00, 1'b0, 8'h00);
    step("R2 pin sets bit1", 4'b0010, 8'h00, 1'b0, 8'h00);
    step("R4 brown keeps others", 4'b0100, 8'h00, 1'b0, 8'h00);
    step("R2 wdog sets bit3", 4'b1000, 8'h00, 1'b0, 8'h00);
    check("R4 all set", {24'd0, bus_rdata}, 32'h0F);
    step("R5 write 1s keeps", 4'b0000, A_DATA, 1'b1, 8'hFF);
    step("R5 clear bit2 via io alias", 4'b0000, A_IO, 1'b1, 8'hFB);
    step("R7 upper write ignored", 4'b0000, A_DATA, 1'b1, 8'hFF);
    step("R3 pwr clears others", 4'b0001, 8'h00, 1'b0, 8'h00);
    check("R3 only bit0", {24'd0, bus_rdata}, 32'h01);
    step("R5 clear pwr flag", 4'b0000, A_DATA, 1'b1, 8'hF0);
    step("R4 pin leaves bit0", 4'b0010, 8'h00, 1'b0, 8'h00);
    step("R6 miss write ignored", 4'b0000, 8'h55, 1'b1, 8'h00);
    step("R6 miss at 0x14", 4'b0000, 8'h14, 1'b1, 8'h00);
    step("R8 pin beats write zero", 4'b0010, A_DATA, 1'b1, 8'h00);
    step("R3 pwr with wdog", 4'b1001, A_IO, 1'b1, 8'h00);
    step("R8 pwr beats write zero", 4'b0001, A_DATA, 1'b1, 8'h00);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] ev;
      logic [2:0] sel;
      ev[0] = ($urandom % 16) == 0;
      ev[1] = ($urandom % 6) == 0;
      ev[2] = ($urandom % 6) == 0;
      ev[3] = ($urandom % 6) == 0;
      sel = 3'($urandom % 8);
      case (sel)
        3'd0, 3'd1, 3'd2: a = A_DATA;
        3'd3, 3'd4, 3'd5: a = A_IO;
        3'd6:             a = A_DATA ^ 8'($urandom % 255 + 1);
        default:          a = 8'($urandom);
      endcase
      step("R2 R3 R4 R5 R6 R8 random", ev, a, ($urandom % 2) == 0, 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule